// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block gathers device interrupt lines into a small tree and drives a single interrupt request toward the CPU. At the leaf level a group of slot request lines is captured into an inverted-polarity slot flag register. An active-high slot enable register masks it, and the masked result becomes one summary bit of a secondary flag register. The secondary flags are masked again by their own enable register and fold into one bit of the CPU status register. That register also carries four primary sources, a DMA summary taken from two sticky DMA flag registers, a stored mode bit and the CPU interrupt flag.

Software reaches every register through a byte-wide port with a 4-bit address. Reads are combinational. Enable registers are written with a set/clear convention: bit 7 of the written byte chooses set or clear, and the other 1 bits select which enables change. The CPU flag latches on a rising edge of the combined source term and holds until software clears it.

Top module: `irq_tree`

## Requirements
- R1: After reset the CPU status register (address 0) reads 0x00, the secondary flag register (address 1) reads 0x00, both enable registers (addresses 2 and 4) read 0x80, the slot flag register (address 3) reads 0x7F, and `cpuIrq` is 0.
- R2: The slot flag register is active-low. Request line `slotIrq[i]` appears as bit 2+i one clock after it is sampled, and reads 0 while the request is pending. Bits 0 and 1 read 1 and bit 7 reads 0.
- R3: Bit 1 of the secondary flag register is 1 when any pending slot request has its slot enable bit set. Slot enables live in bits 2 to 6 of address 4.
- R4: The secondary flag register shows `devIrq[0..3]` in bits 0, 3, 4 and 5, one clock after they are sampled. Its bit 7 reads the OR of all flags whose secondary enable bit (address 2) is set.
- R5: A write to an enable register with bit 7 = 1 sets every enable bit whose written bit is 1. With bit 7 = 0 it clears those bits. Bits that do not exist stay 0, and enable reads return bit 7 as 1.
- R6: Addresses 9 and 10 behave exactly as addresses 1 and 2, for both reads and writes.
- R7: CPU status bits 0 to 5 are, in order: `primIrq[0]`, the secondary summary, `primIrq[1]`, `primIrq[2]`, the OR of both DMA flag registers, and `primIrq[3]`. DMA flag registers (addresses 5 and 6) latch `dmaSet` pulses and clear the bits written as 1.
- R8: CPU status bit 6 is a read/write mode bit. Writes leave bits 0 to 5 of the CPU register unchanged.
- R9: The CPU flag (status bit 7, driven out as `cpuIrq`) sets one clock after the OR of status bits 0 to 5 rises. It stays set and is cleared by writing 1 to bit 7. A level that stays high does not set the flag again.
- R10: When a set event and a software clear reach the same flag in the same cycle, the set wins. This applies to the CPU flag and to each DMA flag bit.
- R11: Writes to addresses 1, 3 and 9 have no effect. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data |
| slotIrq | input | 5 | Slot requests, active high |
| devIrq | input | 4 | Secondary device requests |
| primIrq | input | 4 | Primary CPU-level sources |
| dmaSet0 | input | 8 | Set pulses for DMA flag register 0 |
| dmaSet1 | input | 8 | Set pulses for DMA flag register 1 |
| cpuIrq | output | 1 | CPU interrupt request |

## Verification
Two functions can land on the same clock edge. The first is a source-term rising edge together with a software write that clears the CPU flag. The second is a DMA set pulse together with a write-one-to-clear of the same DMA bit. The bench provokes the CPU case by raising a primary source one cycle ahead of the clear write, so that the flag's edge detection and the write meet on one edge. It provokes the DMA case by driving the set pulse and the clearing write in the same cycle. In both cases the flag must read as set afterwards, and any lost event is reported as a failure.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADR_CPU       = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_SEC_FLAG  = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_SEC_EN    = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_SLOT_FLAG = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_SLOT_EN   = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_DMA0      = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_DMA1      = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_SEC_FLAG2 = 4'd9;
  localparam logic [ADDR_W-1:0] ADR_SEC_EN2   = 4'd10;

  localparam logic [REG_W-1:0] SEC_EN_MASK     = 8'h3B;
  localparam logic [REG_W-1:0] SLOT_EN_MASK    = 8'h7C;
  localparam logic [REG_W-1:0] SLOT_FLAG_RESET = 8'h7F;
  localparam int               SLOT_BASE       = 2;

  typedef enum logic [2:0] {
    RD_NONE, RD_CPU, RD_SEC_FLAG, RD_SEC_EN,
    RD_SLOT_FLAG, RD_SLOT_EN, RD_DMA0, RD_DMA1
  } rdSel_e;

  typedef struct packed {
    logic   wrCpu;
    logic   wrSecEn;
    logic   wrSlotEn;
    logic   wrDma0;
    logic   wrDma1;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
  import irq_tree_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb
);
  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    unique case (addr)
      ADR_CPU: begin
        stb.rdSel = RD_CPU;
        stb.wrCpu = wrEn;
      end
      ADR_SEC_FLAG, ADR_SEC_FLAG2: stb.rdSel = RD_SEC_FLAG;
      ADR_SEC_EN, ADR_SEC_EN2: begin
        stb.rdSel   = RD_SEC_EN;
        stb.wrSecEn = wrEn;
      end
      ADR_SLOT_FLAG: stb.rdSel = RD_SLOT_FLAG;
      ADR_SLOT_EN: begin
        stb.rdSel    = RD_SLOT_EN;
        stb.wrSlotEn = wrEn;
      end
      ADR_DMA0: begin
        stb.rdSel  = RD_DMA0;
        stb.wrDma0 = wrEn;
      end
      ADR_DMA1: begin
        stb.rdSel  = RD_DMA1;
        stb.wrDma1 = wrEn;
      end
      default: stb.rdSel = RD_NONE;
    endcase
  end

  // R6: one register target per access, mirrors included
  assert_one_target_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrCpu, stb.wrSecEn, stb.wrSlotEn, stb.wrDma0, stb.wrDma1}));

  // R11: a write to a read-only or unmapped address raises no strobe
  assert_ro_no_strobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == ADR_SEC_FLAG || addr == ADR_SEC_FLAG2 || addr == ADR_SLOT_FLAG))
      |-> !(stb.wrCpu || stb.wrSecEn || stb.wrSlotEn || stb.wrDma0 || stb.wrDma1));
endmodule

// File: rtl/irq_tree_datapath.sv
module irq_tree_datapath
  import irq_tree_pkg::*;
#(
  parameter int SLOT_N = 5,
  parameter int DEV_N  = 4,
  parameter int PRIM_N = 4,
  parameter int DMA_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [REG_W-1:0] wrData,
  input  logic [SLOT_N-1:0] slotIrq,
  input  logic [DEV_N-1:0]  devIrq,
  input  logic [PRIM_N-1:0] primIrq,
  input  logic [DMA_W-1:0]  dmaSet0,
  input  logic [DMA_W-1:0]  dmaSet1,
  output logic [REG_W-1:0]  rdData,
  output logic              cpuIrq
);
  localparam int DEV_POS [4] = '{0, 3, 4, 5};

  logic [REG_W-1:0] slotSample, slotFlagN, slotEn;
  logic [REG_W-1:0] devSample, devLvl, secEn;
  logic [PRIM_N-1:0] primLvl;
  logic [DMA_W-1:0]  dma0, dma1;
  logic              modeBit, cpuFlag, combPrev;

  // Leaf mapping of request lines into register bit positions
  always_comb begin
    slotSample = SLOT_FLAG_RESET;
    devSample  = '0;
  end
  logic [REG_W-1:0] slotMapped, devMapped;
  generate
    for (genvar i = 0; i < REG_W; i++) begin : g_slotMap
      if (i >= SLOT_BASE && i < SLOT_BASE + SLOT_N) begin : g_live
        assign slotMapped[i] = ~slotIrq[i-SLOT_BASE];
      end else begin : g_idle
        assign slotMapped[i] = slotSample[i];
      end
    end
    for (genvar i = 0; i < REG_W; i++) begin : g_devMap
      if (i == DEV_POS[0] && DEV_N > 0) begin : g_d0
        assign devMapped[i] = devIrq[0];
      end else if (i == DEV_POS[1] && DEV_N > 1) begin : g_d1
        assign devMapped[i] = devIrq[1];
      end else if (i == DEV_POS[2] && DEV_N > 2) begin : g_d2
        assign devMapped[i] = devIrq[2];
      end else if (i == DEV_POS[3] && DEV_N > 3) begin : g_d3
        assign devMapped[i] = devIrq[3];
      end else begin : g_none
        assign devMapped[i] = devSample[i];
      end
    end
  endgenerate

  function automatic logic [REG_W-1:0] enUpdate(input logic [REG_W-1:0] cur,
                                                 input logic [REG_W-1:0] data,
                                                 input logic [REG_W-1:0] mask);
    logic [REG_W-1:0] sel;
    sel = data & mask;
    return data[REG_W-1] ? (cur | sel) : (cur & ~sel);
  endfunction

  // Tree summaries
  logic [REG_W-1:0] slotPend, secFlags;
  logic             slotSum, secSum, dmaSum, combTerm, riseEvt, cpuClr;
  logic [5:0]       cpuStat;

  always_comb begin
    slotPend = ~slotFlagN & slotEn & SLOT_EN_MASK;
    slotSum  = |slotPend;
    secFlags = devLvl;
    secFlags[1] = slotSum;
    secSum   = |(secFlags & secEn & SEC_EN_MASK);
    dmaSum   = (|dma0) | (|dma1);
    cpuStat  = {primLvl[3], dmaSum, primLvl[2], primLvl[1], secSum, primLvl[0]};
    combTerm = |cpuStat;
    riseEvt  = combTerm & ~combPrev;
    cpuClr   = stb.wrCpu & wrData[REG_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotFlagN <= SLOT_FLAG_RESET;
      slotEn    <= '0;
      devLvl    <= '0;
      secEn     <= '0;
      primLvl   <= '0;
      dma0      <= '0;
      dma1      <= '0;
      modeBit   <= 1'b0;
      cpuFlag   <= 1'b0;
      combPrev  <= 1'b0;
    end else begin
      slotFlagN <= slotMapped;
      devLvl    <= devMapped;
      primLvl   <= primIrq;
      combPrev  <= combTerm;
      if (stb.wrSlotEn) slotEn <= enUpdate(slotEn, wrData, SLOT_EN_MASK);
      if (stb.wrSecEn)  secEn  <= enUpdate(secEn, wrData, SEC_EN_MASK);
      dma0 <= (dma0 & ~(stb.wrDma0 ? wrData[DMA_W-1:0] : '0)) | dmaSet0;
      dma1 <= (dma1 & ~(stb.wrDma1 ? wrData[DMA_W-1:0] : '0)) | dmaSet1;
      if (stb.wrCpu) modeBit <= wrData[6];
      if (riseEvt)     cpuFlag <= 1'b1;
      else if (cpuClr) cpuFlag <= 1'b0;
    end
  end

  assign cpuIrq = cpuFlag;

  always_comb begin
    unique case (stb.rdSel)
      RD_CPU:       rdData = {cpuFlag, modeBit, cpuStat};
      RD_SEC_FLAG:  rdData = {secSum, secFlags[REG_W-2:0]};
      RD_SEC_EN:    rdData = {1'b1, secEn[REG_W-2:0]};
      RD_SLOT_FLAG: rdData = slotFlagN;
      RD_SLOT_EN:   rdData = {1'b1, slotEn[REG_W-2:0]};
      RD_DMA0:      rdData = REG_W'(dma0);
      RD_DMA1:      rdData = REG_W'(dma1);
      default:      rdData = '0;
    endcase
  end

  // R9: a rising source term sets the CPU flag on the next edge
  assert_flag_sets_R9: assert property (@(posedge clk) disable iff (!rstN)
    (combTerm && !combPrev) |=> cpuFlag);
  // R9: a clear without a concurrent rise drops the flag
  assert_flag_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrCpu && wrData[7] && !(combTerm && !combPrev)) |=> !cpuFlag);
  // R10: set beats clear on the CPU flag
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrCpu && wrData[7] && combTerm && !combPrev) |=> cpuFlag);
  // R5: a set-type enable write leaves every selected bit set
  assert_en_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrSecEn && wrData[7]) |=>
      ((secEn & $past(wrData & SEC_EN_MASK)) == $past(wrData & SEC_EN_MASK)));
  // R7: DMA flags are sticky unless written
  assert_dma_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((|dma0) && !stb.wrDma0) |=> (|dma0));
endmodule

// File: rtl/irq_tree.sv
module irq_tree
  import irq_tree_pkg::*;
#(
  parameter int SLOT_N = 5,
  parameter int DEV_N  = 4,
  parameter int PRIM_N = 4,
  parameter int DMA_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic [SLOT_N-1:0] slotIrq,
  input  logic [DEV_N-1:0]  devIrq,
  input  logic [PRIM_N-1:0] primIrq,
  input  logic [DMA_W-1:0]  dmaSet0,
  input  logic [DMA_W-1:0]  dmaSet1,
  output logic              cpuIrq
);
  strobe_t stb;

  irq_tree_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .stb(stb)
  );

  irq_tree_datapath #(
    .SLOT_N(SLOT_N), .DEV_N(DEV_N), .PRIM_N(PRIM_N), .DMA_W(DMA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .slotIrq(slotIrq), .devIrq(devIrq), .primIrq(primIrq),
    .dmaSet0(dmaSet0), .dmaSet1(dmaSet1),
    .rdData(rdData), .cpuIrq(cpuIrq)
  );
endmodule

// File: tb/irq_tree_bench.sv
module irq_tree_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [4:0] slotIrq = '0;
  logic [3:0] devIrq = '0;
  logic [3:0] primIrq = '0;
  logic [7:0] dmaSet0 = '0;
  logic [7:0] dmaSet1 = '0;
  logic       cpuIrq;
  int         errors = 0;
  int         checks = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  irq_tree u_irq_tree (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .slotIrq(slotIrq), .devIrq(devIrq), .primIrq(primIrq),
    .dmaSet0(dmaSet0), .dmaSet1(dmaSet1), .cpuIrq(cpuIrq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdData;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet();
    slotIrq = '0; devIrq = '0; primIrq = '0;
    wr(4'd2, 8'h7F); wr(4'd4, 8'h7F);
    wr(4'd5, 8'hFF); wr(4'd6, 8'hFF);
    idle(2);
    wr(4'd0, 8'h80);
  endtask

  task automatic testReset();
    logic [7:0] v;
    rd(4'd0, v); check("R1 cpu", v, 8'h00);
    rd(4'd1, v); check("R1 secFlag", v, 8'h00);
    rd(4'd2, v); check("R1 secEn", v, 8'h80);
    rd(4'd3, v); check("R1 slotFlag", v, 8'h7F);
    rd(4'd4, v); check("R1 slotEn", v, 8'h80);
    check("R1 cpuIrq", {7'b0, cpuIrq}, 8'h00);
  endtask

  task automatic testSlots();
    logic [7:0] v;
    wr(4'd4, 8'hFC);
    @(negedge clk); slotIrq = 5'b00001;
    idle(1);
    rd(4'd3, v); check("R2 slot0 bit2 low", v, 8'h7B);
    rd(4'd1, v); check("R3 slot summary", v, 8'h02);
    wr(4'd4, 8'h04);
    rd(4'd1, v); check("R3 masked slot", v, 8'h00);
    @(negedge clk); slotIrq = 5'b10000;
    idle(1);
    rd(4'd3, v); check("R2 vbl bit6 low", v, 8'h3F);
    rd(4'd1, v); check("R3 vbl summary", v, 8'h02);
    slotIrq = '0;
  endtask

  task automatic testSecondary();
    logic [7:0] v;
    quiet();
    @(negedge clk); devIrq = 4'hF;
    idle(1);
    rd(4'd1, v); check("R4 dev positions", v, 8'h39);
    wr(4'd2, 8'h88);
    rd(4'd1, v); check("R4 summary bit7", v, 8'hB9);
    rd(4'd0, v); check("R7 cpu bit1", v & 8'h7F, 8'h02);
    devIrq = '0;
  endtask

  task automatic testEnable();
    logic [7:0] v;
    wr(4'd2, 8'h7F);
    wr(4'd2, 8'hBB); rd(4'd2, v); check("R5 set", v, 8'hBB);
    wr(4'd2, 8'h03); rd(4'd2, v); check("R5 clear", v, 8'hB8);
    wr(4'd2, 8'hC4); rd(4'd2, v); check("R5 unused bits", v, 8'hB8);
    wr(4'd4, 8'hFF); rd(4'd4, v); check("R5 slot set", v, 8'hFC);
  endtask

  task automatic testMirror();
    logic [7:0] v;
    wr(4'd10, 8'h7F); rd(4'd2, v); check("R6 mirror clear", v, 8'h80);
    wr(4'd10, 8'h90); rd(4'd2, v); check("R6 mirror write", v, 8'h90);
    rd(4'd10, v); check("R6 mirror read en", v, 8'h90);
    @(negedge clk); devIrq = 4'b0100;
    idle(1);
    rd(4'd9, v); check("R6 mirror read flag", v, 8'h90);
    devIrq = '0;
  endtask

  task automatic testCpuBits();
    logic [7:0] v;
    quiet();
    @(negedge clk); primIrq = 4'b0001; idle(1);
    rd(4'd0, v); check("R7 via bit0", v & 8'h7F, 8'h01);
    @(negedge clk); primIrq = 4'b0010; idle(1);
    rd(4'd0, v); check("R7 serial bit2", v & 8'h7F, 8'h04);
    @(negedge clk); primIrq = 4'b0100; idle(1);
    rd(4'd0, v); check("R7 ether bit3", v & 8'h7F, 8'h08);
    @(negedge clk); primIrq = 4'b1000; idle(1);
    rd(4'd0, v); check("R7 nmi bit5", v & 8'h7F, 8'h20);
    primIrq = '0;
    @(negedge clk); dmaSet1 = 8'h08;
    @(negedge clk); dmaSet1 = '0;
    rd(4'd6, v); check("R7 dma1 latched", v, 8'h08);
    rd(4'd0, v); check("R7 dma bit4", v & 8'h7F, 8'h10);
    wr(4'd6, 8'h08);
    rd(4'd6, v); check("R7 dma w1c", v, 8'h00);
  endtask

  task automatic testMode();
    logic [7:0] v;
    quiet();
    wr(4'd0, 8'h40); rd(4'd0, v); check("R8 mode set", v, 8'h40);
    wr(4'd0, 8'h3F); rd(4'd0, v); check("R8 ro bits", v, 8'h00);
  endtask

  task automatic testFlag();
    logic [7:0] v;
    quiet();
    @(negedge clk); primIrq = 4'b0001;
    @(negedge clk); check("R9 not yet", {7'b0, cpuIrq}, 8'h00);
    @(negedge clk); check("R9 set", {7'b0, cpuIrq}, 8'h01);
    idle(3); check("R9 held", {7'b0, cpuIrq}, 8'h01);
    wr(4'd0, 8'h80);
    check("R9 cleared", {7'b0, cpuIrq}, 8'h00);
    idle(3); check("R9 level no reset", {7'b0, cpuIrq}, 8'h00);
    rd(4'd0, v); check("R9 flag bit7 low", v, 8'h01);
    primIrq = '0; idle(2);
    @(negedge clk); primIrq = 4'b1000; idle(2);
    rd(4'd0, v); check("R9 new rise", v, 8'hA0);
    primIrq = '0;
  endtask

  task automatic testCollide();
    logic [7:0] v;
    quiet();
    @(negedge clk); primIrq = 4'b0001; idle(2);
    primIrq = '0; idle(2);
    check("R10 precondition", {7'b0, cpuIrq}, 8'h01);
    @(negedge clk); primIrq = 4'b0001;
    @(negedge clk); wrEn = 1'b1; addr = 4'd0; wrData = 8'h80;
    @(negedge clk); wrEn = 1'b0;
    check("R10 cpu set wins", {7'b0, cpuIrq}, 8'h01);
    primIrq = '0;
    @(negedge clk); dmaSet0 = 8'h08;
    @(negedge clk); dmaSet0 = '0;
    @(negedge clk); wrEn = 1'b1; addr = 4'd5; wrData = 8'h09; dmaSet0 = 8'h01;
    @(negedge clk); wrEn = 1'b0; dmaSet0 = '0;
    rd(4'd5, v); check("R10 dma set wins", v, 8'h01);
  endtask

  task automatic testReadOnly();
    logic [7:0] v;
    quiet();
    wr(4'd3, 8'h00); rd(4'd3, v); check("R11 slotFlag ro", v, 8'h7F);
    @(negedge clk); devIrq = 4'b0001; idle(1);
    wr(4'd1, 8'hFF); rd(4'd1, v); check("R11 secFlag ro", v, 8'h01);
    wr(4'd9, 8'h00); rd(4'd1, v); check("R11 mirror ro", v, 8'h01);
    devIrq = '0;
    rd(4'd7, v); check("R11 unmapped", v, 8'h00);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    testReset();
    testSlots();
    testSecondary();
    testEnable();
    testMirror();
    testCpuBits();
    testMode();
    testFlag();
    testCollide();
    testReadOnly();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule